// File: doc/BRIEF.md
# Shadowed SRAM store/recall controller

This block fronts a memory held in two copies: a volatile working array reached through an asynchronous-SRAM style port, and a non-volatile shadow array. The port has active-low chip select, output enable and write enable. It also has an active-low hardware-save strobe. The controller turns those pins into read and write cycles and remembers whether any write has landed since the two copies last matched. It moves the whole array between the copies when one of four things happens: power arriving, a power-fail warning, the hardware-save strobe, or a software request.

A transfer takes a fixed, parameterised number of clocks. It copies every word in one step on its final clock, and all array access is shut out until it ends. Saves triggered by the strobe or by power-fail are skipped when nothing has been written since the last save or restore. A software save always runs. After a power-fail save, the controller stays parked until power-good returns, and then restores the working array from the shadow. The pins are sampled on the clock and are assumed to be already synchronised. Supply sensing is represented only by the digital `pwr_fail` and `pwr_good` inputs.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, `busy` is 1 and the controller is parked. Once `pwr_good` is seen high, a restore runs for RECALL_CYC clocks. `busy` then drops and the working array holds the shadow contents. Before any save, shadow word i holds i XOR INIT_XOR.
- R2: When a clock edge samples `ce_n`=0, `oe_n`=0, `we_n`=1 and `hs_n`=1 while idle, the next cycle has `rd_oe`=1 and `rdata` equal to the working word at the sampled `addr`. Each such edge follows a new address.
- R3: `rd_oe` is 0 in the cycle after any edge that saw `ce_n` high, `oe_n` high, `we_n` low or `hs_n` low.
- R4: A write is active on edges that see `ce_n`=0, `we_n`=0 and `hs_n`=1 while idle. The first edge that sees it inactive commits the `addr` and `wdata` sampled on the last active edge, and this commit marks the array dirty.
- R5: An edge that sees `hs_n` go from 1 to 0 while idle starts a save lasting STORE_CYC clocks if the array is dirty. If the array is clean the strobe has no effect and `busy` stays 0.
- R6: A `sw_store` pulse while idle always starts a save of STORE_CYC clocks, whether the array is dirty or clean.
- R7: A `sw_recall` pulse while idle starts a restore of RECALL_CYC clocks. Afterwards, writes made since the last save are replaced by the shadow contents.
- R8: `pwr_fail` while idle either saves (when dirty) or skips the save (when clean). In both cases the controller then holds `busy`=1 for as long as `pwr_good` is 0, and runs the R1 restore when it returns.
- R9: The completion of any save or restore clears the dirty mark. A strobe that follows it is ignored until a new write commits.
- R10: While `busy` is 1, reads give `rd_oe`=0 and writes change no word.
- R11: When several requests arrive on one idle edge, the order is `pwr_fail`, then the strobe, then `sw_store`, then `sw_recall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hs_n | input | 1 | Hardware-save strobe, active low, falling edge acts |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| rd_oe | output | 1 | Read data drive enable; bus tri-stated when 0 |
| sw_store | input | 1 | Software save request pulse |
| sw_recall | input | 1 | Software restore request pulse |
| pwr_fail | input | 1 | Supply falling warning |
| pwr_good | input | 1 | Supply present |
| busy | output | 1 | Transfer running or parked, access blocked |

## Verification
The bench builds the block with AW=3 (eight words), STORE_CYC=5, RECALL_CYC=3 and INIT_XOR=8'h3C. At that size every word can be read back after each save and restore, and the length of every busy window can be counted to the exact clock. The short transfer lengths leave room to try writes and reads inside a save window, and to run all four request sources, both power-fail paths and the simultaneous-request ordering in one short run.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_DOWN   = 3'd0,
    ST_PUR    = 3'd1,
    ST_IDLE   = 3'd2,
    ST_STORE  = 3'd3,
    ST_RECALL = 3'd4
  } nvs_state_e;
endpackage

// File: rtl/nvs_port_dec.sv
// Pin-level cycle decoder: read request and release-edge write commit.
module nvs_port_dec #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hs_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_req,
  output logic          wr_commit,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data
);
  logic wr_cond;
  logic wr_act_q;

  always_comb begin
    rd_req    = idle & ~ce_n & ~oe_n & we_n & hs_n;
    wr_cond   = idle & ~ce_n & ~we_n & hs_n;
    wr_commit = wr_act_q & ~wr_cond & idle;
  end

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_cond;
  end

  // last sampled address and data of an active write
  always_ff @(posedge clk) begin
    if (wr_cond) begin
      cm_addr <= addr;
      cm_data <= wdata;
    end
  end
endmodule

// File: rtl/nvs_seq.sv
// Transfer sequencer: request arbitration, dirty tracking, busy timer.
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hs_n,
  input  logic       sw_store,
  input  logic       sw_recall,
  input  logic       pwr_fail,
  input  logic       pwr_good,
  input  logic       wr_commit,
  output nvs_state_e state,
  output logic       idle,
  output logic       busy,
  output logic       dirty,
  output logic       xfer_done,
  output logic       do_store,
  output logic       do_recall
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ST_LOAD = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RC_LOAD = CW'(RECALL_CYC - 1);

  nvs_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          dirty_q, dirty_d;
  logic          hs_prev_q;
  logic          in_xfer, hs_fall, dirty_eff;

  always_comb begin
    in_xfer   = (state_q == ST_STORE) || (state_q == ST_RECALL) || (state_q == ST_PUR);
    xfer_done = in_xfer && (cnt_q == '0);
    do_store  = xfer_done && (state_q == ST_STORE);
    do_recall = xfer_done && (state_q != ST_STORE);
    hs_fall   = hs_prev_q & ~hs_n;
    dirty_eff = dirty_q | wr_commit;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    case (state_q)
      ST_IDLE: begin
        if (pwr_fail) begin
          if (dirty_eff) begin
            state_d = ST_STORE;
            cnt_d   = ST_LOAD;
            pend_d  = 1'b1;
          end else begin
            state_d = ST_DOWN;
          end
        end else if ((hs_fall && dirty_eff) || sw_store) begin
          state_d = ST_STORE;
          cnt_d   = ST_LOAD;
        end else if (sw_recall) begin
          state_d = ST_RECALL;
          cnt_d   = RC_LOAD;
        end
      end
      ST_STORE, ST_RECALL, ST_PUR: begin
        if (pwr_fail) pend_d = 1'b1;
        if (cnt_q == '0) begin
          state_d = (pend_q || pwr_fail) ? ST_DOWN : ST_IDLE;
          pend_d  = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DOWN: begin
        if (pwr_good) begin
          state_d = ST_PUR;
          cnt_d   = RC_LOAD;
        end
      end
      default: state_d = ST_DOWN;
    endcase
  end

  always_comb begin
    dirty_d = dirty_q;
    if (wr_commit)      dirty_d = 1'b1;
    else if (xfer_done) dirty_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_DOWN;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      dirty_q   <= 1'b0;
      hs_prev_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      pend_q    <= pend_d;
      dirty_q   <= dirty_d;
      hs_prev_q <= hs_n;
    end
  end

  assign state = state_q;
  assign idle  = (state_q == ST_IDLE);
  assign busy  = (state_q != ST_IDLE);
  assign dirty = dirty_q;
endmodule

// File: rtl/nvs_arrays.sv
// Working and shadow word arrays with single-step whole-array copy.
module nvs_arrays #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [DW-1:0] INIT_XOR = 'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          do_store,
  input  logic          do_recall,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] work_q   [DEPTH];
  logic [DW-1:0] shadow_q [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      work_q[i]   = '0;
      shadow_q[i] = DW'(i) ^ INIT_XOR;
    end
  end

  always_ff @(posedge clk) begin
    if (do_recall) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= shadow_q[i];
    end else if (wr_en) begin
      work_q[wr_addr] <= wr_data;
    end
    if (do_store) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= work_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= work_q[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 8,
  parameter int STORE_CYC  = 16,
  parameter int RECALL_CYC = 8,
  parameter logic [DW-1:0] INIT_XOR = 'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hs_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_oe,
  input  logic          sw_store,
  input  logic          sw_recall,
  input  logic          pwr_fail,
  input  logic          pwr_good,
  output logic          busy
);
  nvs_state_e    state;
  logic          idle, dirty, xfer_done, do_store, do_recall;
  logic          rd_req, wr_commit;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  nvs_port_dec #(.AW(AW), .DW(DW)) dec_i (
    .clk(clk), .rst(rst), .idle(idle),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hs_n(hs_n),
    .addr(addr), .wdata(wdata),
    .rd_req(rd_req), .wr_commit(wr_commit),
    .cm_addr(cm_addr), .cm_data(cm_data)
  );

  nvs_seq #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) seq_i (
    .clk(clk), .rst(rst), .hs_n(hs_n),
    .sw_store(sw_store), .sw_recall(sw_recall),
    .pwr_fail(pwr_fail), .pwr_good(pwr_good),
    .wr_commit(wr_commit),
    .state(state), .idle(idle), .busy(busy), .dirty(dirty),
    .xfer_done(xfer_done), .do_store(do_store), .do_recall(do_recall)
  );

  nvs_arrays #(.AW(AW), .DW(DW), .INIT_XOR(INIT_XOR)) arr_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_commit), .wr_addr(cm_addr), .wr_data(cm_data),
    .rd_en(rd_req), .rd_addr(addr),
    .do_store(do_store), .do_recall(do_recall),
    .rd_data(rdata), .rd_valid(rd_oe)
  );
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
  import nvs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       hs_n,
  input logic       sw_store,
  input logic       sw_recall,
  input logic       pwr_fail,
  input logic       pwr_good,
  input logic       busy,
  input logic       rd_oe,
  input logic       dirty,
  input logic       wr_commit,
  input logic       xfer_done,
  input nvs_state_e state
);
  // R10
  busy_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rd_oe);

  // R3
  read_needs_pins_chk: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> $past(!ce_n && !oe_n && we_n && hs_n));

  // R5
  clean_strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(hs_n) && state == ST_IDLE && !dirty && !wr_commit && !pwr_fail &&
     !sw_store && !sw_recall) |=> !busy);

  // R6
  sw_store_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_store && state == ST_IDLE) |=> busy);

  // R8
  parked_until_good_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOWN && !pwr_good) |=> state == ST_DOWN);

  // R9
  dirty_clears_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dirty) |-> $past(xfer_done));
endmodule

bind nvs_ctrl nvs_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hs_n(hs_n),
  .sw_store(sw_store), .sw_recall(sw_recall), .pwr_fail(pwr_fail),
  .pwr_good(pwr_good), .busy(busy), .rd_oe(rd_oe), .dirty(dirty),
  .wr_commit(wr_commit), .xfer_done(xfer_done), .state(state)
);

// File: tb/nvs_ctrl_tb_top.sv
module nvs_ctrl_tb_top;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int SC = 5;
  localparam int RC = 3;
  localparam logic [7:0] IX = 8'h3C;
  localparam int DEPTH = 1 << AW;
  localparam int M_DOWN = 0, M_PUR = 1, M_IDLE = 2, M_STORE = 3, M_RECALL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1, oe_n = 1, we_n = 1, hs_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_oe, busy;
  logic sw_store = 0, sw_recall = 0, pwr_fail = 0, pwr_good = 0;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  nvs_ctrl #(.AW(AW), .DW(DW), .STORE_CYC(SC), .RECALL_CYC(RC), .INIT_XOR(IX)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hs_n(hs_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe),
    .sw_store(sw_store), .sw_recall(sw_recall),
    .pwr_fail(pwr_fail), .pwr_good(pwr_good), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_work [DEPTH];
  int m_shad [DEPTH];
  int m_st, m_cnt, m_waddr, m_wdata, m_rd;
  bit m_dirty, m_pend, m_hsp, m_wact, m_oe;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_work[i] = 0;
      m_shad[i] = i ^ int'(IX);
    end
  end

  always @(posedge clk) begin
    bit idle, wrc, rdc, com, deff;
    cyc++;
    if (rst) begin
      m_st = M_DOWN; m_cnt = 0; m_dirty = 0; m_pend = 0;
      m_hsp = 1; m_wact = 0; m_oe = 0;
    end else begin
      idle = (m_st == M_IDLE);
      wrc  = idle && !ce_n && !we_n && hs_n;
      rdc  = idle && !ce_n && !oe_n && we_n && hs_n;
      com  = m_wact && !wrc && idle;
      deff = m_dirty || com;
      if (rdc) m_rd = m_work[addr];
      m_oe = rdc;
      case (m_st)
        M_IDLE: begin
          if (pwr_fail) begin
            if (deff) begin m_st = M_STORE; m_cnt = SC - 1; m_pend = 1; end
            else m_st = M_DOWN;
          end else if ((m_hsp && !hs_n && deff) || sw_store) begin
            m_st = M_STORE; m_cnt = SC - 1;
          end else if (sw_recall) begin
            m_st = M_RECALL; m_cnt = RC - 1;
          end
        end
        M_DOWN: if (pwr_good) begin m_st = M_PUR; m_cnt = RC - 1; end
        default: begin
          if (m_cnt == 0) begin
            if (m_st == M_STORE) for (int i = 0; i < DEPTH; i++) m_shad[i] = m_work[i];
            else                 for (int i = 0; i < DEPTH; i++) m_work[i] = m_shad[i];
            m_dirty = 0;
            m_st = (m_pend || pwr_fail) ? M_DOWN : M_IDLE;
            m_pend = 0;
          end else begin
            if (pwr_fail) m_pend = 1;
            m_cnt--;
          end
        end
      endcase
      if (com) begin m_work[m_waddr] = m_wdata; m_dirty = 1; end
      m_wact = wrc;
      if (wrc) begin m_waddr = addr; m_wdata = wdata; end
      m_hsp = hs_n;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy === (m_st != M_IDLE), "R10 busy vs model", busy, m_st != M_IDLE);
      chk(rd_oe === m_oe, "R3 rd_oe vs model", rd_oe, m_oe);
      if (m_oe) chk(rdata === DW'(m_rd), "R2 rdata vs model", rdata, m_rd);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic bus_idle();
    ce_n = 1; oe_n = 1; we_n = 1; hs_n = 1;
    sw_store = 0; sw_recall = 0; pwr_fail = 0;
  endtask

  task automatic read_chk(input int a, input int exp, input string tag);
    ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
    @(negedge clk);
    chk(rd_oe === 1'b1 && rdata === DW'(exp), tag, rdata, exp);
    bus_idle();
  endtask

  task automatic write_word(input int a, input int d);
    ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    bus_idle();
    repeat (3) @(negedge clk);
    chk(busy === 1'b1, "R1 busy in reset", busy, 1);
    rst = 0;
    repeat (4) @(negedge clk);
    chk(busy === 1'b1, "R1 parked without pwr_good", busy, 1);
    pwr_good = 1;
    @(negedge clk);
    count_busy(n);
    chk(n == RC, "R1 power-up restore length", n, RC);
    for (int i = 0; i < DEPTH; i++) read_chk(i, i ^ int'(IX), "R1 restored word");

    // R2: streaming reads follow address each cycle
    ce_n = 0; oe_n = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      addr = AW'(i);
      @(negedge clk);
      chk(rd_oe === 1'b1 && rdata === DW'(i ^ int'(IX)), "R2 stream read", rdata, i ^ int'(IX));
    end
    bus_idle();

    // R4
    write_word(1, 8'h11);
    read_chk(1, 8'h11, "R4 write committed");

    // R3
    ce_n = 1; oe_n = 0; addr = 1;
    @(negedge clk);
    chk(rd_oe === 1'b0, "R3 ce_n high blocks read", rd_oe, 0);
    ce_n = 0; oe_n = 1;
    @(negedge clk);
    chk(rd_oe === 1'b0, "R3 oe_n high blocks read", rd_oe, 0);
    bus_idle();
    @(negedge clk);

    // R5 dirty strobe
    hs_n = 0;
    @(negedge clk);
    hs_n = 1;
    count_busy(n);
    chk(n == SC, "R5 strobe save length", n, SC);
    // R5 / R9 clean strobe ignored
    hs_n = 0;
    @(negedge clk);
    hs_n = 1;
    chk(busy === 1'b0, "R9 clean strobe ignored", busy, 0);
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R5 still idle", busy, 0);

    // R6
    sw_store = 1;
    @(negedge clk);
    sw_store = 0;
    count_busy(n);
    chk(n == SC, "R6 clean software save runs", n, SC);

    // R7
    write_word(2, 8'h5A);
    read_chk(2, 8'h5A, "R4 second write");
    sw_recall = 1;
    @(negedge clk);
    sw_recall = 0;
    count_busy(n);
    chk(n == RC, "R7 restore length", n, RC);
    read_chk(2, 2 ^ int'(IX), "R7 unsaved write replaced");
    read_chk(1, 8'h11, "R7 saved word kept");
    hs_n = 0;
    @(negedge clk);
    hs_n = 1;
    chk(busy === 1'b0, "R9 strobe after restore ignored", busy, 0);
    @(negedge clk);

    // R10
    sw_store = 1;
    @(negedge clk);
    sw_store = 0;
    ce_n = 0; we_n = 0; addr = 3; wdata = 8'hEE;
    @(negedge clk);
    we_n = 1; oe_n = 0;
    @(negedge clk);
    chk(rd_oe === 1'b0, "R10 read blocked while busy", rd_oe, 0);
    bus_idle();
    count_busy(n);
    read_chk(3, 3 ^ int'(IX), "R10 write during save ignored");

    // R11
    write_word(4, 8'h99);
    sw_store = 1; sw_recall = 1;
    @(negedge clk);
    sw_store = 0; sw_recall = 0;
    count_busy(n);
    chk(n == SC, "R11 save wins over restore", n, SC);
    read_chk(4, 8'h99, "R11 word after save");
    sw_recall = 1;
    @(negedge clk);
    sw_recall = 0;
    count_busy(n);
    read_chk(4, 8'h99, "R11 saved word restored");

    // R8 clean power fail
    pwr_fail = 1; pwr_good = 0;
    @(negedge clk);
    pwr_fail = 0;
    repeat (10) @(negedge clk);
    chk(busy === 1'b1, "R8 parked after clean fail", busy, 1);
    pwr_good = 1;
    @(negedge clk);
    count_busy(n);
    chk(n == RC, "R8 restore after power back", n, RC);
    read_chk(4, 8'h99, "R8 data after clean fail");

    // R8 dirty power fail
    write_word(5, 8'h77);
    pwr_fail = 1; pwr_good = 0;
    @(negedge clk);
    pwr_fail = 0;
    repeat (SC + 5) @(negedge clk);
    chk(busy === 1'b1, "R8 parked after dirty fail", busy, 1);
    pwr_good = 1;
    @(negedge clk);
    count_busy(n);
    chk(n == RC, "R8 restore after dirty fail", n, RC);
    read_chk(5, 8'h77, "R8 written word survived");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule